// File: doc/BRIEF.md
# Processor Status Flag Register

This block keeps the eight status flags of an 8-bit accumulator processor and updates them once per clock from the datapath. The ALU hands over its result byte, its carry and overflow outputs and per-flag enables. The shifter hands over the bit it shifted out. The decoder hands over flag set/clear commands, a bit-test strobe with its memory operand, interrupt-entry and break strobes, and a restore strobe with the byte popped from the stack on return from interrupt.

The block outputs the live flag byte, the interrupt mask, an accept signal for hardware interrupt requests, the decimal-mode and memory-to-memory-mode indications, and the byte to push on interrupt entry. In the pushed byte the break bit marks a software break. In the live register the break bit is always zero.

Inside the block, a control module turns the command and strobe inputs into a small struct of per-flag strobes. A datapath module applies those strobes in a fixed priority order to form the next flag byte.

Top module: `statusFlags`

## Requirements
- R1: Bit layout of `flags` is C=0, Z=1, I=2, D=3, B=4, T=5, V=6, N=7. While reset is low, and right after it, I reads 1. The other flags are unspecified after reset.
- R2: Bit 4 of `flags` reads 0 at all times, including after a restore of a byte that has bit 4 set and after a break entry.
- R3: The `flagCmd` codes are 1 set C, 2 clear C, 3 set I, 4 clear I, 5 set D, 6 clear D, 7 set T, 8 clear T and 9 clear V. Code 0 and codes 10 to 15 change no flag.
- R4: With its enable high, Z loads 1 when `aluResult` is zero and 0 otherwise, N loads `aluResult[7]`, and V loads `aluOverflow`.
- R5: With `updC` high, C loads `shiftOut` when `carrySel` is 1, and `aluCarry` when `carrySel` is 0.
- R6: With `bitOp` high, V loads `bitOperand[6]` and N loads `bitOperand[7]`. These loads take precedence over `updV` and `updN`.
- R7: When a set/clear command and an ALU or bit-test update target the same flag in one cycle, the command decides that flag.
- R8: A cycle with `irqEntry` or `brkEntry` high leaves I at 1 afterwards. This holds even when a clear-I command or a restore is given in the same cycle.
- R9: `irqTake` equals `irqReq` while I is 0 and is 0 while I is 1. `intMask` mirrors I. A break entry is performed whatever the value of I.
- R10: `pushByte` equals `flags` except bit 4, which equals `brkEntry` in the same cycle.
- R11: With `restoreEn` high, the next flag byte is `restoreByte` with bit 4 forced to 0. The restore overrides commands and ALU updates given in the same cycle.
- R12: `decimalMode` mirrors D and `tMode` mirrors T. With D at 1, C still loads from the ALU carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| flagCmd | input | 4 | Flag set/clear command code |
| updC | input | 1 | Load C this cycle |
| updZ | input | 1 | Load Z from the ALU result |
| updV | input | 1 | Load V from the ALU overflow |
| updN | input | 1 | Load N from the ALU result sign |
| carrySel | input | 1 | C source: 1 shifter, 0 ALU |
| shiftOut | input | 1 | Bit shifted out by a shift or rotate |
| aluCarry | input | 1 | ALU carry or borrow |
| aluOverflow | input | 1 | ALU signed overflow |
| aluResult | input | 8 | ALU result byte |
| bitOp | input | 1 | Bit-test instruction strobe |
| bitOperand | input | 8 | Memory operand of the bit test |
| irqReq | input | 1 | Hardware interrupt request |
| irqEntry | input | 1 | Hardware interrupt entry strobe |
| brkEntry | input | 1 | Software break entry strobe |
| restoreEn | input | 1 | Restore flags from the stack byte |
| restoreByte | input | 8 | Byte popped from the stack |
| flags | output | 8 | Live flag byte |
| intMask | output | 1 | Interrupt mask (I) |
| irqTake | output | 1 | Hardware request accepted |
| decimalMode | output | 1 | Decimal arithmetic selected (D) |
| tMode | output | 1 | Memory-to-memory mode (T) |
| pushByte | output | 8 | Flag byte to push on entry |

## Verification
The collisions of interest are a flag command arriving in the same cycle as a datapath update of the same flag, and an interrupt or break entry arriving in the same cycle as a clear-I command or a restore. The bench drives both inputs of each pair on one edge: clear-carry against a carry of 1, set-carry against a carry of 0, clear-overflow against a bit test with bit 6 set, clear-I against a break entry, and a restore of zero against an interrupt entry. For each collision it checks the affected flag on the next edge against the winner that the priority rules name.

// File: rtl/statusFlags_pkg.sv
package statusFlags_pkg;

  localparam int DATA_W = 8;

  localparam int POS_C = 0;
  localparam int POS_Z = 1;
  localparam int POS_I = 2;
  localparam int POS_D = 3;
  localparam int POS_B = 4;
  localparam int POS_T = 5;
  localparam int POS_V = 6;
  localparam int POS_N = 7;

  localparam int CMD_W = 4;

  localparam logic [DATA_W-1:0] B_BIT      = DATA_W'(1) << POS_B;
  localparam logic [DATA_W-1:0] RESET_WORD = DATA_W'(1) << POS_I;

  typedef enum logic [CMD_W-1:0] {
    CMD_NONE = 4'd0,
    CMD_SEC  = 4'd1,
    CMD_CLC  = 4'd2,
    CMD_SEI  = 4'd3,
    CMD_CLI  = 4'd4,
    CMD_SED  = 4'd5,
    CMD_CLD  = 4'd6,
    CMD_SET  = 4'd7,
    CMD_CLT  = 4'd8,
    CMD_CLV  = 4'd9
  } flagCmd_e;

  typedef struct packed {
    logic [DATA_W-1:0] setMask;
    logic [DATA_W-1:0] clrMask;
    logic              ldC;
    logic              ldZ;
    logic              ldV;
    logic              ldN;
    logic              ldBit;
    logic              restore;
    logic              enterInt;
  } flagStrobe_t;

endpackage

// File: rtl/flagCtrl.sv
module flagCtrl
  import statusFlags_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [CMD_W-1:0] flagCmd,
  input  logic        updC,
  input  logic        updZ,
  input  logic        updV,
  input  logic        updN,
  input  logic        bitOp,
  input  logic        restoreEn,
  input  logic        irqEntry,
  input  logic        brkEntry,
  input  logic        irqReq,
  input  logic        iFlag,
  output flagStrobe_t stb,
  output logic        irqTake
);

  flagCmd_e cmd;
  assign cmd = flagCmd_e'(flagCmd);

  always_comb begin
    stb = '0;
    case (cmd)
      CMD_SEC: stb.setMask[POS_C] = 1'b1;
      CMD_CLC: stb.clrMask[POS_C] = 1'b1;
      CMD_SEI: stb.setMask[POS_I] = 1'b1;
      CMD_CLI: stb.clrMask[POS_I] = 1'b1;
      CMD_SED: stb.setMask[POS_D] = 1'b1;
      CMD_CLD: stb.clrMask[POS_D] = 1'b1;
      CMD_SET: stb.setMask[POS_T] = 1'b1;
      CMD_CLT: stb.clrMask[POS_T] = 1'b1;
      CMD_CLV: stb.clrMask[POS_V] = 1'b1;
      default: ;
    endcase
    stb.ldC      = updC;
    stb.ldZ      = updZ;
    // a bit test owns V and N for its cycle
    stb.ldV      = updV & ~bitOp;
    stb.ldN      = updN & ~bitOp;
    stb.ldBit    = bitOp;
    stb.restore  = restoreEn;
    stb.enterInt = irqEntry | brkEntry;
  end

  // hardware requests are held off by I; the break path never looks at it
  assign irqTake = irqReq & ~iFlag;

  AST_ONE_FLAG_PER_CMD: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(stb.setMask | stb.clrMask)); // R3

  AST_NO_SET_ON_B: assert property (@(posedge clk) disable iff (!rstN)
    !stb.setMask[POS_B]); // R2

endmodule

// File: rtl/flagPath.sv
module flagPath
  import statusFlags_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  flagStrobe_t       stb,
  input  logic              carrySel,
  input  logic              shiftOut,
  input  logic              aluCarry,
  input  logic              aluOverflow,
  input  logic [DATA_W-1:0] aluResult,
  input  logic [DATA_W-1:0] bitOperand,
  input  logic [DATA_W-1:0] restoreByte,
  output logic [DATA_W-1:0] q
);

  logic [DATA_W-1:0] fromData;
  logic [DATA_W-1:0] afterCmd;
  logic [DATA_W-1:0] nxt;

  // stage 1: datapath loads
  always_comb begin
    fromData = q;
    if (stb.ldC) fromData[POS_C] = carrySel ? shiftOut : aluCarry;
    if (stb.ldZ) fromData[POS_Z] = (aluResult == '0);
    if (stb.ldV) fromData[POS_V] = aluOverflow;
    if (stb.ldN) fromData[POS_N] = aluResult[DATA_W-1];
    if (stb.ldBit) begin
      fromData[POS_V] = bitOperand[POS_V];
      fromData[POS_N] = bitOperand[POS_N];
    end
  end

  // stage 2: explicit commands override datapath loads
  assign afterCmd = (fromData | stb.setMask) & ~stb.clrMask;

  // stage 3: restore overrides all, entry forces I, B never stored
  always_comb begin
    nxt = stb.restore ? restoreByte : afterCmd;
    if (stb.enterInt) nxt[POS_I] = 1'b1;
    nxt[POS_B] = 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) q <= RESET_WORD;
    else       q <= nxt;
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    $past(!stb.restore) |-> ((q & $past(stb.setMask)) == $past(stb.setMask))); // R7

  AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rstN)
    $past(!stb.restore && !stb.enterInt) |-> ((q & $past(stb.clrMask)) == '0)); // R7

  AST_ENTRY_SETS_I: assert property (@(posedge clk) disable iff (!rstN)
    $past(stb.enterInt) |-> q[POS_I]); // R8

  AST_RESTORE_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    $past(stb.restore && !stb.enterInt) |-> (q == ($past(restoreByte) & ~B_BIT))); // R11

  AST_BIT_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    $past(stb.ldBit && !stb.restore && stb.clrMask == '0)
      |-> (q[POS_N:POS_V] == $past(bitOperand[POS_N:POS_V]))); // R6

endmodule

// File: rtl/statusFlags.sv
module statusFlags
  import statusFlags_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [3:0] flagCmd,
  input  logic       updC,
  input  logic       updZ,
  input  logic       updV,
  input  logic       updN,
  input  logic       carrySel,
  input  logic       shiftOut,
  input  logic       aluCarry,
  input  logic       aluOverflow,
  input  logic [7:0] aluResult,
  input  logic       bitOp,
  input  logic [7:0] bitOperand,
  input  logic       irqReq,
  input  logic       irqEntry,
  input  logic       brkEntry,
  input  logic       restoreEn,
  input  logic [7:0] restoreByte,
  output logic [7:0] flags,
  output logic       intMask,
  output logic       irqTake,
  output logic       decimalMode,
  output logic       tMode,
  output logic [7:0] pushByte
);

  flagStrobe_t stb;

  flagCtrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .flagCmd   (flagCmd),
    .updC      (updC),
    .updZ      (updZ),
    .updV      (updV),
    .updN      (updN),
    .bitOp     (bitOp),
    .restoreEn (restoreEn),
    .irqEntry  (irqEntry),
    .brkEntry  (brkEntry),
    .irqReq    (irqReq),
    .iFlag     (flags[POS_I]),
    .stb       (stb),
    .irqTake   (irqTake)
  );

  flagPath u_path (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .carrySel    (carrySel),
    .shiftOut    (shiftOut),
    .aluCarry    (aluCarry),
    .aluOverflow (aluOverflow),
    .aluResult   (aluResult),
    .bitOperand  (bitOperand),
    .restoreByte (restoreByte),
    .q           (flags)
  );

  assign intMask     = flags[POS_I];
  assign decimalMode = flags[POS_D];
  assign tMode       = flags[POS_T];

  always_comb begin
    pushByte        = flags;
    pushByte[POS_B] = brkEntry;
  end

  AST_PUSH_MIRRORS_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    ((pushByte & ~B_BIT) == flags)); // R10

  AST_MASK_BLOCKS_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    intMask |-> !irqTake); // R9

  AST_LIVE_B_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !flags[POS_B]); // R2

endmodule

// File: tb/statusFlags_bench.sv
module statusFlags_bench;

  logic       clk = 1'b0;
  logic       rstN;
  logic [3:0] flagCmd;
  logic       updC, updZ, updV, updN, carrySel, shiftOut, aluCarry, aluOverflow;
  logic [7:0] aluResult;
  logic       bitOp;
  logic [7:0] bitOperand;
  logic       irqReq, irqEntry, brkEntry, restoreEn;
  logic [7:0] restoreByte;
  logic [7:0] flags, pushByte;
  logic       intMask, irqTake, decimalMode, tMode;

  int testsRun = 0;
  int testsFailed = 0;

  always #5 clk = ~clk;

  statusFlags u_statusFlags (
    .clk(clk), .rstN(rstN), .flagCmd(flagCmd),
    .updC(updC), .updZ(updZ), .updV(updV), .updN(updN),
    .carrySel(carrySel), .shiftOut(shiftOut), .aluCarry(aluCarry),
    .aluOverflow(aluOverflow), .aluResult(aluResult),
    .bitOp(bitOp), .bitOperand(bitOperand),
    .irqReq(irqReq), .irqEntry(irqEntry), .brkEntry(brkEntry),
    .restoreEn(restoreEn), .restoreByte(restoreByte),
    .flags(flags), .intMask(intMask), .irqTake(irqTake),
    .decimalMode(decimalMode), .tMode(tMode), .pushByte(pushByte)
  );

  // vector: command, enables {updC updZ updV updN carrySel shiftOut aluCarry aluOverflow},
  // ALU result, bit-test strobe, operand, checked-bit mask, expected bits
  typedef struct packed {
    logic [3:0] cmd;
    logic [7:0] ctl;
    logic [7:0] res;
    logic       bitEn;
    logic [7:0] bitVal;
    logic [7:0] expMask;
    logic [7:0] expVal;
  } vec_t;

  localparam int NVEC = 19;
  localparam vec_t VEC [NVEC] = '{
    {4'd2, 8'b0000_0000, 8'h00, 1'b0, 8'h00, 8'h01, 8'h00}, // R3 clear C
    {4'd1, 8'b0000_0000, 8'h00, 1'b0, 8'h00, 8'h01, 8'h01}, // R3 set C
    {4'd5, 8'b0000_0000, 8'h00, 1'b0, 8'h00, 8'h08, 8'h08}, // R3 set D
    {4'd6, 8'b0000_0000, 8'h00, 1'b0, 8'h00, 8'h08, 8'h00}, // R3 clear D
    {4'd7, 8'b0000_0000, 8'h00, 1'b0, 8'h00, 8'h20, 8'h20}, // R3 set T
    {4'd8, 8'b0000_0000, 8'h00, 1'b0, 8'h00, 8'h20, 8'h00}, // R3 clear T
    {4'd4, 8'b0000_0000, 8'h00, 1'b0, 8'h00, 8'h04, 8'h00}, // R3 clear I
    {4'd3, 8'b0000_0000, 8'h00, 1'b0, 8'h00, 8'h04, 8'h04}, // R3 set I
    {4'd9, 8'b0000_0000, 8'h00, 1'b0, 8'h00, 8'h40, 8'h00}, // R3 clear V
    {4'd0, 8'b1111_0011, 8'h00, 1'b0, 8'h00, 8'hC3, 8'h43}, // R4 zero result
    {4'd0, 8'b1111_0000, 8'h80, 1'b0, 8'h00, 8'hC3, 8'h80}, // R4 negative result
    {4'd0, 8'b1000_1100, 8'h00, 1'b0, 8'h00, 8'h01, 8'h01}, // R5 shifter carry
    {4'd0, 8'b0000_0000, 8'h00, 1'b1, 8'h40, 8'hC0, 8'h40}, // R6 bit test 6
    {4'd0, 8'b0011_0000, 8'h00, 1'b1, 8'h80, 8'hC0, 8'h80}, // R6 bit test over ALU
    {4'd2, 8'b1000_0010, 8'h00, 1'b0, 8'h00, 8'h01, 8'h00}, // R7 clear C vs carry 1
    {4'd1, 8'b1000_0000, 8'h00, 1'b0, 8'h00, 8'h01, 8'h01}, // R7 set C vs carry 0
    {4'd9, 8'b0000_0000, 8'h00, 1'b1, 8'h40, 8'hC0, 8'h00}, // R7 clear V vs bit test
    {4'd0, 8'b0100_0000, 8'h05, 1'b0, 8'h00, 8'h02, 8'h00}, // R4 nonzero result
    {4'd15,8'b0000_0000, 8'h00, 1'b0, 8'h00, 8'hFF, 8'h05}  // R3 unused code
  };

  function automatic string reqOf(int idx);
    if (idx < 9)                              return "R3";
    if (idx == 9 || idx == 10 || idx == 17)   return "R4";
    if (idx == 11)                            return "R5";
    if (idx == 12 || idx == 13)               return "R6";
    if (idx >= 14 && idx <= 16)               return "R7";
    return "R3";
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic idle();
    flagCmd = 4'd0; updC = 0; updZ = 0; updV = 0; updN = 0;
    carrySel = 0; shiftOut = 0; aluCarry = 0; aluOverflow = 0; aluResult = 8'h00;
    bitOp = 0; bitOperand = 8'h00; irqReq = 0; irqEntry = 0; brkEntry = 0;
    restoreEn = 0; restoreByte = 8'h00;
  endtask

  // apply the driven inputs for one edge, then return to the falling edge idle
  task automatic tick();
    @(posedge clk); #1;
    @(negedge clk);
    idle();
  endtask

  task automatic cmdStep(input logic [3:0] c);
    flagCmd = c;
    tick();
  endtask

  initial begin
    #1_000_000;
    testsFailed++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    idle();
    rstN = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset I", {7'b0, flags[2]}, 8'h01);
    chk("R2 reset B", {7'b0, flags[4]}, 8'h00);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 I after release", {7'b0, flags[2]}, 8'h01);

    for (int i = 0; i < NVEC; i++) begin
      flagCmd  = VEC[i].cmd;
      {updC, updZ, updV, updN, carrySel, shiftOut, aluCarry, aluOverflow} = VEC[i].ctl;
      aluResult  = VEC[i].res;
      bitOp      = VEC[i].bitEn;
      bitOperand = VEC[i].bitVal;
      @(posedge clk); #1;
      chk(reqOf(i), flags & (VEC[i].expMask | 8'h10), VEC[i].expVal);
      @(negedge clk);
      idle();
    end

    // R12 decimal and T mode outputs; carry still loads in decimal mode
    cmdStep(4'd5);
    chk("R12 decimalMode", {7'b0, decimalMode}, 8'h01);
    updC = 1; aluCarry = 0; tick();
    chk("R12 C in decimal", {7'b0, flags[0]}, 8'h00);
    updC = 1; aluCarry = 1; tick();
    chk("R12 C in decimal", {7'b0, flags[0]}, 8'h01);
    cmdStep(4'd6);
    cmdStep(4'd7);
    chk("R12 tMode", {7'b0, tMode}, 8'h01);
    cmdStep(4'd8);
    chk("R12 tMode clear", {7'b0, tMode}, 8'h00);

    // R9 masking
    cmdStep(4'd4);
    irqReq = 1; #1;
    chk("R9 irqTake unmasked", {7'b0, irqTake}, 8'h01);
    chk("R9 intMask low", {7'b0, intMask}, 8'h00);
    flagCmd = 4'd3; tick();
    irqReq = 1; #1;
    chk("R9 irqTake masked", {7'b0, irqTake}, 8'h00);
    chk("R9 intMask high", {7'b0, intMask}, 8'h01);
    idle();

    // R10/R8 hardware entry with I clear
    cmdStep(4'd4);
    irqEntry = 1; #1;
    chk("R10 push on irq", pushByte, flags);
    chk("R10 push B on irq", {7'b0, pushByte[4]}, 8'h00);
    tick();
    chk("R8 I after irq", {7'b0, flags[2]}, 8'h01);

    // R10/R9/R2 break with I set
    brkEntry = 1; #1;
    chk("R10 push B on brk", {7'b0, pushByte[4]}, 8'h01);
    chk("R10 push rest on brk", pushByte & 8'hEF, flags);
    tick();
    chk("R9 break taken with I set", {7'b0, flags[2]}, 8'h01);
    chk("R2 live B after brk", {7'b0, flags[4]}, 8'h00);

    // R8 collision: clear-I with break entry
    flagCmd = 4'd4; brkEntry = 1; tick();
    chk("R8 entry beats clear I", {7'b0, flags[2]}, 8'h01);

    // R11 restore
    restoreEn = 1; restoreByte = 8'hFF; tick();
    chk("R11 restore FF", flags, 8'hEF);
    chk("R2 restore B", {7'b0, flags[4]}, 8'h00);
    restoreEn = 1; restoreByte = 8'h00; flagCmd = 4'd1; updZ = 1; aluResult = 8'h00; tick();
    chk("R11 restore beats cmd", flags, 8'h00);
    restoreEn = 1; restoreByte = 8'h00; irqEntry = 1; tick();
    chk("R8 entry beats restore", flags, 8'h04);

    // R1 reset mid-run
    restoreEn = 1; restoreByte = 8'h3B; tick();
    chk("R11 restore 3B", flags, 8'h2B);
    rstN = 1'b0;
    @(negedge clk);
    chk("R1 reset I mid-run", {7'b0, flags[2]}, 8'h01);
    rstN = 1'b1;
    @(negedge clk);

    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule